// File: doc/BRIEF.md
# Serial Control Slave with Blanking-Timed Settings

This block connects a slow synchronous serial host bus to the noise-reduction core. The host sends frames made of one address byte and one data byte. The block keeps a small register file holding a filter preference and a noise threshold. Writes land in shadow copies. The filter core sees new values only when vertical blanking begins, so the settings never change part way through a picture.

The bus has one clock line and one data line, with no parity. The data line is bidirectional. At this block's edge it is split into an input, an output and an output enable, and the pad joins them. The bus clock and the data line are brought into the fast system clock domain through two flip-flops each. A bit is captured when the block sees a rising edge on the synchronized bus clock.

The vertical blanking input does two jobs. Its rising edge publishes the shadow registers to the filter core. While it is high, the serial receiver is held idle.

Top module: `serial_ctl_slave`

## Requirements
- R1: After reset, `pref_o` is 0 (filtering off), `thr_o` is `THR_RST` (default 8'h20), and `data_oe` is low.
- R2: A frame is an address byte followed by a data byte, each sent MSB first. Each bit is taken on a rising edge of `bus_clk`. An address with bit 7 set starts a write.
- R3: A write to address 8'hF9 stores the data byte as the threshold shadow. A write to address 8'hF8 stores it as the preference shadow.
- R4: A preference byte from 0 to 10 is accepted: 0 turns filtering off, and 1 to 10 select a filter type. A value of 11 to 255 leaves the preference shadow unchanged. `pref_o` never exceeds 10.
- R5: `pref_o` and `thr_o` change only in the cycle after `vbi` is first seen high, when they take the shadow values. At every other time they hold steady.
- R6: An address with bit 7 clear is a read. The block selects the register from the low 7 bits: 7'h79 gives the threshold shadow, 7'h78 gives the preference shadow zero-extended, and any other value gives 8'h00. For the next eight `bus_clk` rising edges the block asserts `data_oe` and drives the value MSB first on `data_o`. It moves to the next bit on each rising edge and releases the line after the eighth.
- R7: While `vbi` is high, bus activity is ignored and any partly received frame is thrown away. The next frame after `vbi` falls starts from a fresh address byte.
- R8: A write to any address other than 8'hF8 or 8'hF9 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbi | input | 1 | Vertical blanking indicator |
| bus_clk | input | 1 | Serial bus clock, idles low |
| data_i | input | 1 | Serial data from the pad |
| data_o | output | 1 | Serial data to the pad during reads |
| data_oe | output | 1 | Pad output enable |
| pref_o | output | 4 | Active preference: 0 means off, 1 to 10 select a filter type |
| thr_o | output | 8 | Active noise threshold |

## Verification
The hardest case to reach from the ports is a blanking pulse that arrives in the middle of a byte. If leftover bit-count state survived that pulse, every later frame would be misaligned. The bench sends five bits of an address, raises `vbi`, then sends a complete write. It checks the published threshold. A second blanking pulse is held high across a whole frame, and a read-back then shows that the frame left no trace. Reads are also used to check rejected preference values and writes to unknown addresses, since those leave no other mark at the ports.

// File: rtl/serial_ctl_slave.sv
module serial_ctl_slave #(
  parameter logic [7:0] THR_RST   = 8'h20,
  parameter logic [6:0] PREF_ADDR = 7'h78,
  parameter logic [6:0] THR_ADDR  = 7'h79,
  parameter int         NUM_PREFS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbi,
  input  logic       bus_clk,
  input  logic       data_i,
  output logic       data_o,
  output logic       data_oe,
  output logic [3:0] pref_o,
  output logic [7:0] thr_o
);

  typedef enum logic [1:0] {PH_ADDR, PH_WR, PH_RD} phase_t;

  logic [2:0] sc_s;
  logic [1:0] sd_s;
  logic       vbi_q;
  phase_t     phase;
  logic [2:0] cnt;
  logic [7:0] sh, tx;
  logic [6:0] addr;
  logic [3:0] pref_sh;
  logic [7:0] thr_sh;

  wire       rise   = sc_s[1] & ~sc_s[2];
  wire       bin    = sd_s[1];
  wire [7:0] byte_n = {sh[6:0], bin};
  wire       last   = (cnt == 3'd7);

  function automatic logic [7:0] rd_val(input logic [6:0] a,
                                        input logic [3:0] p,
                                        input logic [7:0] t);
    if (a == THR_ADDR)       return t;
    else if (a == PREF_ADDR) return {4'd0, p};
    else                     return 8'd0;
  endfunction

  assign data_o = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_s    <= '0;
      sd_s    <= '0;
      vbi_q   <= 1'b0;
      phase   <= PH_ADDR;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      addr    <= '0;
      data_oe <= 1'b0;
      pref_sh <= '0;
      thr_sh  <= THR_RST;
      pref_o  <= '0;
      thr_o   <= THR_RST;
    end else begin
      sc_s  <= {sc_s[1:0], bus_clk};
      sd_s  <= {sd_s[0], data_i};
      vbi_q <= vbi;
      if (vbi && !vbi_q) begin
        pref_o <= pref_sh;
        thr_o  <= thr_sh;
      end
      if (vbi) begin
        phase   <= PH_ADDR;
        cnt     <= '0;
        data_oe <= 1'b0;
      end else if (rise) begin
        cnt <= cnt + 3'd1;
        unique case (phase)
          PH_ADDR: begin
            sh <= byte_n;
            if (last) begin
              addr <= byte_n[6:0];
              if (byte_n[7]) phase <= PH_WR;
              else begin
                phase   <= PH_RD;
                tx      <= rd_val(byte_n[6:0], pref_sh, thr_sh);
                data_oe <= 1'b1;
              end
            end
          end
          PH_WR: begin
            sh <= byte_n;
            if (last) begin
              phase <= PH_ADDR;
              if (addr == THR_ADDR) thr_sh <= byte_n;
              if (addr == PREF_ADDR && byte_n <= 8'(NUM_PREFS))
                pref_sh <= byte_n[3:0];
            end
          end
          PH_RD: begin
            tx <= {tx[6:0], 1'b0};
            if (last) begin
              phase   <= PH_ADDR;
              data_oe <= 1'b0;
            end
          end
          default: phase <= PH_ADDR;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_ctl_slave_chk.sv
module serial_ctl_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vbi,
  input logic       data_oe,
  input logic [3:0] pref_o,
  input logic [7:0] thr_o
);

  logic vbi_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vbi_d <= 1'b0;
    else        vbi_d <= vbi;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pref_o == 4'd0 && !data_oe));

  assert_pref_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pref_o <= 4'd10);

  assert_hold_outside_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbi || vbi_d) |=> ($stable(pref_o) && $stable(thr_o)));

  assert_idle_in_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vbi |=> !data_oe);

endmodule

bind serial_ctl_slave serial_ctl_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vbi(vbi), .data_oe(data_oe),
  .pref_o(pref_o), .thr_o(thr_o)
);

// File: tb/tb_serial_ctl_slave.sv
module tb_serial_ctl_slave;
  logic clk = 0, rst_n = 0, vbi = 0, bus_clk = 0, data_i = 0;
  logic data_o, data_oe;
  logic [3:0] pref_o;
  logic [7:0] thr_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_ctl_slave dut (.clk(clk), .rst_n(rst_n), .vbi(vbi), .bus_clk(bus_clk),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .pref_o(pref_o), .thr_o(thr_o));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    data_i = b;  wait_clk(4);
    bus_clk = 1; wait_clk(6);
    bus_clk = 0; wait_clk(4);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    send_byte(a); send_byte(d);
  endtask

  task automatic rd(logic [6:0] a, output logic [7:0] v, input string req);
    send_byte({1'b0, a});
    for (int i = 7; i >= 0; i--) begin
      check({req, " oe during read"}, data_oe, 1);
      v[i] = data_o;
      send_bit(1'b0);
    end
    check({req, " oe released"}, data_oe, 0);
  endtask

  task automatic blank();
    vbi = 1; wait_clk(4);
    vbi = 0; wait_clk(2);
  endtask

  task automatic t_reset();
    check("R1 pref", pref_o, 0);
    check("R1 thr", thr_o, 8'h20);
    check("R1 oe", data_oe, 0);
  endtask

  task automatic t_write_publish();
    wr(8'hF9, 8'h5A);
    wr(8'hF8, 8'h07);
    check("R5 pref held before blank", pref_o, 0);
    check("R5 thr held before blank", thr_o, 8'h20);
    blank();
    check("R3 thr published", thr_o, 8'h5A);
    check("R3 pref published", pref_o, 7);
  endtask

  task automatic t_read();
    logic [7:0] v;
    rd(7'h79, v, "R6"); check("R6 read thr", v, 8'h5A);
    rd(7'h78, v, "R6"); check("R6 read pref", v, 8'h07);
    rd(7'h10, v, "R6"); check("R6 read unknown", v, 8'h00);
  endtask

  task automatic t_msb_order();
    logic [7:0] v;
    wr(8'hF9, 8'h81);
    rd(7'h79, v, "R2"); check("R2 MSB-first byte", v, 8'h81);
    wr(8'hF9, 8'h5A);
  endtask

  task automatic t_pref_range();
    logic [7:0] v;
    wr(8'hF8, 8'h0B);
    rd(7'h78, v, "R4"); check("R4 value 11 rejected", v, 8'h07);
    wr(8'hF8, 8'hF3);
    rd(7'h78, v, "R4"); check("R4 value 0xF3 rejected", v, 8'h07);
    wr(8'hF8, 8'h0A);
    rd(7'h78, v, "R4"); check("R4 value 10 accepted", v, 8'h0A);
    blank();
    check("R4 pref 10 published", pref_o, 10);
  endtask

  task automatic t_other_addr();
    logic [7:0] v;
    wr(8'hF0, 8'hFF);
    wr(8'hFA, 8'h03);
    rd(7'h79, v, "R8"); check("R8 thr untouched", v, 8'h5A);
    rd(7'h78, v, "R8"); check("R8 pref untouched", v, 8'h0A);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    blank();
    wr(8'hF9, 8'h33);
    blank();
    check("R7 aligned after partial", thr_o, 8'h33);
    vbi = 1; wait_clk(2);
    wr(8'hF9, 8'h99);
    check("R7 oe low in blank", data_oe, 0);
    vbi = 0; wait_clk(2);
    rd(7'h79, v, "R7"); check("R7 frame in blank ignored", v, 8'h33);
    wr(8'hF8, 8'h00);
    blank();
    check("R4 pref off published", pref_o, 0);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(3);
    t_reset();
    t_write_publish();
    t_read();
    t_msb_order();
    t_pref_range();
    t_other_addr();
    t_partial();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule